// File: doc/BRIEF.md
# Configurable-Latency Signed/Unsigned Multiply Unit

This block is the multiplier of a 16-bit RISC coprocessor core. A start strobe, sampled on a rising clock edge while the unit is idle, captures a source word, an operand word and a two-bit operation code. After a fixed number of cycles, the unit raises a single-cycle done strobe. In that same cycle it presents a 16-bit primary result together with sign and zero flags. For the full-width operation it also presents a 16-bit secondary low word, with a write-enable pulse.

There are four operations.

| Code | Operation | Factors | Primary result | Secondary low word |
|------|-----------|---------|----------------|--------------------|
| 0 | Signed byte multiply | Low bytes of both inputs | 16-bit product | Not written |
| 1 | Unsigned byte multiply | Low bytes of both inputs | 16-bit product | Not written |
| 2 | Signed word multiply, upper half | Full source and operand words | Upper 16 bits of the 32-bit product | Not written |
| 3 | Signed word multiply, full product | Full source and operand words | Upper 16 bits of the 32-bit product | Lower 16 bits, with write-enable pulse |

For the word forms, the instruction decoder routes a fixed implicit register onto the operand input. The surrounding core steers the primary result into the destination register, and it steers the secondary low word into the fixed low-word register.

A speed-select input picks the latency. It is sampled with the start strobe. Fast mode takes `FAST_LAT` cycles, and slow mode takes twice as many. The results and flags hold between operations.

Top module: `mul_unit`

## Requirements
- R1: After reset, the outputs are as follows: `busy_o`, `done_o` and `lo_we_o` are 0; `res_o` and `lo_o` are 0x0000; `neg_o` is 0; `zero_o` is 1.
- R2: Operation code 0 multiplies the two's-complement low bytes of `src_i` and `opnd_i` and returns the 16-bit product on `res_o`. For example, bytes 0xCF and 0xCF give 0x0961.
- R3: Operation code 1 multiplies the unsigned low bytes and returns the 16-bit product on `res_o`. For example, bytes 0x4F and 0xCF give 0x3FE1.
- R4: Operation code 3 forms the signed 16x16 product. It places bits 31:16 on `res_o` and bits 15:0 on `lo_o`, and it pulses `lo_we_o` only in the `done_o` cycle. For example, 0xB556 times 0xDAAB gives 0x0AE3 and 0x5C72.
- R5: Operation code 2 forms the same signed 16x16 product and places bits 31:16 on `res_o`. It never raises `lo_we_o`, and `lo_o` keeps its previous value.
- R6: For operation codes 0 and 1, the upper bytes of both inputs have no effect on `res_o`.
- R7: In fast mode (`slow_i` = 0 at start), `done_o` rises exactly `FAST_LAT` rising edges after the edge that accepted the start.
- R8: In slow mode (`slow_i` = 1 at start), `done_o` rises exactly 2*`FAST_LAT` edges after the accepting edge.
- R9: `done_o` is a one-cycle pulse. `busy_o` is high from the accepting edge until the edge that raises `done_o`.
- R10: A start strobe while `busy_o` is high is ignored. It produces no extra `done_o` and does not alter the result of the running operation.
- R11: `neg_o` equals bit 15 of `res_o`, and `zero_o` is 1 exactly when `res_o` is 0x0000. Both flags update together with the result.
- R12: `res_o`, `lo_o` and the flags hold their values in every cycle in which `done_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe; accepted only when idle |
| op_i | input | 2 | Operation code: 0 signed byte, 1 unsigned byte, 2 signed word upper half, 3 signed word full |
| slow_i | input | 1 | Latency select, sampled with start: 0 fast, 1 slow |
| src_i | input | 16 | Source word (first factor) |
| opnd_i | input | 16 | Operand word (second factor; the implicit register for word forms) |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion strobe |
| res_o | output | 16 | Primary result |
| lo_o | output | 16 | Secondary low word of the full product |
| lo_we_o | output | 1 | Write enable for `lo_o`, full-product operation only |
| neg_o | output | 1 | Sign flag of `res_o` |
| zero_o | output | 1 | Zero flag of `res_o` |

## Verification
The bench targets operands whose bit 7 or bit 15 is set, together with non-zero upper bytes. These cases catch a unit that confuses sign extension with zero extension, or that lets the upper byte leak into a byte product. An upper-half operation follows a full-product one, which exposes a design that writes or clobbers the low word when it should not. The latency is measured edge by edge in both speed modes, so an off-by-one counter or an ignored speed select shows up as a mismatch. A second start is issued mid-operation, so a design that restarts or double-completes produces an extra or corrupted done. Zero and negative results check that the flags follow the primary word.

// File: rtl/mul_pkg.sv
package mul_pkg;

  typedef enum logic [1:0] {
    MOP_S8     = 2'd0,
    MOP_U8     = 2'd1,
    MOP_HI16   = 2'd2,
    MOP_FULL16 = 2'd3
  } mop_e;

  // Widen a factor to 17 signed bits according to the operation
  function automatic logic signed [16:0] widen_factor(mop_e op, logic [15:0] w);
    logic signed [16:0] r;
    case (op)
      MOP_S8:  r = {{9{w[7]}}, w[7:0]};
      MOP_U8:  r = {9'd0, w[7:0]};
      default: r = {w[15], w};
    endcase
    return r;
  endfunction

  // Signed 17x17 product, lower 32 bits kept
  function automatic logic [31:0] mul_core(logic signed [16:0] a, logic signed [16:0] b);
    logic signed [33:0] p;
    p = a * b;
    return p[31:0];
  endfunction

  // Word presented on the primary output
  function automatic logic [15:0] pick_primary(mop_e op, logic [31:0] p);
    return (op == MOP_S8 || op == MOP_U8) ? p[15:0] : p[31:16];
  endfunction

  function automatic logic writes_low(mop_e op);
    return op == MOP_FULL16;
  endfunction

endpackage

// File: rtl/mul_seq_ctrl.sv
module mul_seq_ctrl #(
  parameter int FAST_LAT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic slow_i,
  output logic accept_o,
  output logic busy_o,
  output logic finish_o
);
  localparam int SLOW_LAT = 2 * FAST_LAT;
  localparam int CW       = $clog2(SLOW_LAT + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lat_q;   // latency chosen at accept (verification aid)
  logic [CW-1:0] el_q;    // cycles elapsed since accept (verification aid)
  logic          busy_q;

  assign accept_o = start_i & ~busy_q;
  assign finish_o = busy_q & (cnt_q == '0);
  assign busy_o   = busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      lat_q  <= '0;
      el_q   <= '0;
    end else if (accept_o) begin
      busy_q <= 1'b1;
      cnt_q  <= slow_i ? CW'(SLOW_LAT - 1) : CW'(FAST_LAT - 1);
      lat_q  <= slow_i ? CW'(SLOW_LAT) : CW'(FAST_LAT);
      el_q   <= CW'(1);
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
      el_q <= el_q + 1'b1;
    end
  end

  // R7 / R8: completion falls exactly at the selected latency
  assert_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    finish_o |-> (el_q == lat_q));

  // R10: a running operation is never restarted
  assert_no_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !finish_o) |=> (busy_q && el_q == $past(el_q) + 1'b1));

  assert_cnt_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (int'(cnt_q) < SLOW_LAT));

endmodule

// File: rtl/mul_datapath.sv
module mul_datapath
  import mul_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        accept_i,
  input  mop_e        op_i,
  input  logic [15:0] src_i,
  input  logic [15:0] opnd_i,
  output mop_e        op_o,
  output logic [31:0] prod_o
);
  logic signed [16:0] fa_q, fb_q;
  mop_e               op_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fa_q <= '0;
      fb_q <= '0;
      op_q <= MOP_S8;
    end else if (accept_i) begin
      fa_q <= widen_factor(op_i, src_i);
      fb_q <= widen_factor(op_i, opnd_i);
      op_q <= op_i;
    end
  end

  assign prod_o = mul_core(fa_q, fb_q);
  assign op_o   = op_q;

  // R2: a signed byte product always fits a sign-extended 16-bit word
  assert_s8_fit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_q == MOP_S8) |-> (prod_o[31:16] == {16{prod_o[15]}}));

  // R3: an unsigned byte product never reaches the upper word
  assert_u8_fit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_q == MOP_U8) |-> (prod_o[31:16] == 16'h0000));

endmodule

// File: rtl/mul_result_reg.sv
module mul_result_reg
  import mul_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        finish_i,
  input  mop_e        op_i,
  input  logic [31:0] prod_i,
  output logic        done_o,
  output logic [15:0] res_o,
  output logic [15:0] lo_o,
  output logic        lo_we_o,
  output logic        neg_o,
  output logic        zero_o
);
  logic [15:0] prim;
  assign prim = pick_primary(op_i, prod_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_o  <= 1'b0;
      res_o   <= '0;
      lo_o    <= '0;
      lo_we_o <= 1'b0;
      neg_o   <= 1'b0;
      zero_o  <= 1'b1;
    end else begin
      done_o  <= finish_i;
      lo_we_o <= finish_i & writes_low(op_i);
      if (finish_i) begin
        res_o  <= prim;
        neg_o  <= prim[15];
        zero_o <= (prim == 16'h0000);
        if (writes_low(op_i)) lo_o <= prod_i[15:0];
      end
    end
  end

  assert_lowe_with_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lo_we_o |-> done_o);

  assert_low_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !lo_we_o |-> $stable(lo_o));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_flags_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_o == (res_o == 16'h0000)) && (neg_o == res_o[15]));

  assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(res_o) && $stable(neg_o) && $stable(zero_o)));

endmodule

// File: rtl/mul_unit.sv
module mul_unit
  import mul_pkg::*;
#(
  parameter int FAST_LAT = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic [1:0]  op_i,
  input  logic        slow_i,
  input  logic [15:0] src_i,
  input  logic [15:0] opnd_i,
  output logic        busy_o,
  output logic        done_o,
  output logic [15:0] res_o,
  output logic [15:0] lo_o,
  output logic        lo_we_o,
  output logic        neg_o,
  output logic        zero_o
);
  logic        accept;
  logic        finish;
  mop_e        op_run;
  logic [31:0] prod;

  mul_seq_ctrl #(.FAST_LAT(FAST_LAT)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .slow_i   (slow_i),
    .accept_o (accept),
    .busy_o   (busy_o),
    .finish_o (finish)
  );

  mul_datapath u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept_i (accept),
    .op_i     (mop_e'(op_i)),
    .src_i    (src_i),
    .opnd_i   (opnd_i),
    .op_o     (op_run),
    .prod_o   (prod)
  );

  mul_result_reg u_res (
    .clk      (clk),
    .rst_n    (rst_n),
    .finish_i (finish),
    .op_i     (op_run),
    .prod_i   (prod),
    .done_o   (done_o),
    .res_o    (res_o),
    .lo_o     (lo_o),
    .lo_we_o  (lo_we_o),
    .neg_o    (neg_o),
    .zero_o   (zero_o)
  );

  // R9: busy ends on the edge that raises done
  assert_busy_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

endmodule

// File: tb/mul_unit_tb.sv
module mul_unit_tb;
  localparam int FAST_LAT = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [1:0]  op_i = 2'd0;
  logic        slow_i = 1'b0;
  logic [15:0] src_i = '0;
  logic [15:0] opnd_i = '0;
  logic        busy_o, done_o, lo_we_o, neg_o, zero_o;
  logic [15:0] res_o, lo_o;

  mul_unit #(.FAST_LAT(FAST_LAT)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i), .slow_i(slow_i),
    .src_i(src_i), .opnd_i(opnd_i), .busy_o(busy_o), .done_o(done_o),
    .res_o(res_o), .lo_o(lo_o), .lo_we_o(lo_we_o), .neg_o(neg_o), .zero_o(zero_o)
  );

  always #4 clk = ~clk;   // 125 MHz

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    logic [15:0] res;
    logic [15:0] lo;
    logic        lo_we;
    int          start_cyc;
    int          lat;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  logic [15:0] model_lo = 16'h0000;
  logic [15:0] last_res = 16'h0000;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Reference arithmetic written independently of the design
  function automatic logic [31:0] ref_product(logic [1:0] op, logic [15:0] a, logic [15:0] b);
    longint x, y;
    if (op == 2'd1) begin
      x = longint'(a & 16'h00FF);
      y = longint'(b & 16'h00FF);
    end else if (op == 2'd0) begin
      x = (a[7] == 1'b1) ? longint'(a[7:0]) - 256 : longint'(a[7:0]);
      y = (b[7] == 1'b1) ? longint'(b[7:0]) - 256 : longint'(b[7:0]);
    end else begin
      x = (a[15] == 1'b1) ? longint'(a) - 65536 : longint'(a);
      y = (b[15] == 1'b1) ? longint'(b) - 65536 : longint'(b);
    end
    return 32'(x * y);
  endfunction

  // Driver: waits for idle, issues one start, pushes the expectation
  task automatic issue(logic [1:0] op, logic slow, logic [15:0] a, logic [15:0] b, string tag);
    exp_t        e;
    logic [31:0] p;
    while (busy_o) @(negedge clk);
    p = ref_product(op, a, b);
    e.res = (op[1] == 1'b0) ? p[15:0] : p[31:16];
    if (op == 2'd3) model_lo = p[15:0];
    e.lo = model_lo;
    e.lo_we = (op == 2'd3);
    e.start_cyc = cyc + 1;
    e.lat = slow ? 2 * FAST_LAT : FAST_LAT;
    e.tag = tag;
    sb.push_back(e);
    op_i = op; slow_i = slow; src_i = a; opnd_i = b; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic drain();
    while (sb.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // Monitor: compares each completion with the queue head
  always @(negedge clk) begin
    if (rst_n) begin
      if (lo_we_o && !done_o) chk("R4 lo_we outside done", 32'(lo_we_o), 32'd0);
      if (done_o) begin
        if (sb.size() == 0) begin
          chk("R10 unexpected done", 32'(done_o), 32'd0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk({e.tag, " res"}, 32'(res_o), 32'(e.res));
          chk({e.tag, " lo"}, 32'(lo_o), 32'(e.lo));
          chk({e.tag, " lo_we R4/R5"}, 32'(lo_we_o), 32'(e.lo_we));
          chk({e.tag, " latency R7/R8"}, 32'(cyc - e.start_cyc), 32'(e.lat));
          chk({e.tag, " neg R11"}, 32'(neg_o), 32'(e.res[15]));
          chk({e.tag, " zero R11"}, 32'(zero_o), 32'(e.res == 16'h0000));
          chk({e.tag, " busy R9"}, 32'(busy_o), 32'd0);
          last_res = e.res;
        end
      end
    end
  end

  initial begin : watchdog
    #(8 * 20000);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1 busy", 32'(busy_o), 32'd0);
    chk("R1 done", 32'(done_o), 32'd0);
    chk("R1 lo_we", 32'(lo_we_o), 32'd0);
    chk("R1 res", 32'(res_o), 32'd0);
    chk("R1 lo", 32'(lo_o), 32'd0);
    chk("R1 neg", 32'(neg_o), 32'd0);
    chk("R1 zero", 32'(zero_o), 32'd1);

    // R2 / R3 / R6: byte forms, with upper bytes that must be ignored
    issue(2'd0, 1'b0, 16'h52CF, 16'h63CF, "R2 s8");
    issue(2'd0, 1'b0, 16'h00CF, 16'h0030, "R2 s8 neg");
    issue(2'd1, 1'b0, 16'h364F, 16'hB2CF, "R3 u8");
    issue(2'd1, 1'b0, 16'hFFFF, 16'hFFFF, "R3 u8 max");
    issue(2'd0, 1'b0, 16'hAB80, 16'h1280, "R6 s8 upper");
    issue(2'd1, 1'b0, 16'hFF00, 16'h7712, "R6 u8 zero R11");

    // R4 / R5: word forms
    issue(2'd3, 1'b0, 16'hB556, 16'hDAAB, "R4 full");
    issue(2'd2, 1'b0, 16'h7FFF, 16'h8000, "R5 hi");
    issue(2'd3, 1'b1, 16'h8000, 16'h8000, "R4 full slow R8");
    issue(2'd2, 1'b1, 16'h0003, 16'h0005, "R5 hi zero R8");
    issue(2'd0, 1'b1, 16'h00FF, 16'h0001, "R8 s8 slow");
    drain();

    // R10: second start while busy is ignored
    issue(2'd1, 1'b1, 16'h0010, 16'h0010, "R10 first");
    op_i = 2'd3; slow_i = 1'b0; src_i = 16'h1234; opnd_i = 16'h4321; start_i = 1'b1;
    chk("R9 busy during op", 32'(busy_o), 32'd1);
    @(negedge clk);
    start_i = 1'b0;
    drain();
    repeat (6) @(negedge clk);

    // R12: outputs hold while idle
    chk("R12 res hold", 32'(res_o), 32'(last_res));
    chk("R12 lo hold", 32'(lo_o), 32'(model_lo));
    chk("R12 done low", 32'(done_o), 32'd0);
    chk("scoreboard empty", 32'(sb.size()), 32'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule